// File: doc/BRIEF.md
# Horizontal Clamp and Blank Sequencer

This block produces four active-low per-line timing pulses for a sensor readout front end. They are the optical-black clamp, the dummy-pixel clamp, the pre-blank and the horizontal blank. A pixel counter restarts on every line sync pulse (`hdPulse`). A line counter restarts on every field sync pulse (`vdPulse`) and advances on each line sync. Each pulse is shaped by one of four programmable sequences. A clamp or pre-blank sequence holds a start level and two toggle pixel positions. A blank sequence holds only a begin position and an end position.

The lines of a field are split into regions by programmable line-number change positions. The first region always starts at line 0. In each region, a 2-bit pointer picks one of the four sequences for each pulse. The two clamp pulses share one set of three change positions. The pre-blank has its own set of three. The horizontal blank takes seven boundaries from outside the block, which give it eight regions. A single-clamp control makes the dummy clamp copy the optical-black clamp, so only one clamp has to be programmed.

Top module: `hline_clamp_seq`

## Requirements
- R1: While `rstN` is low, all four pulse outputs are high (inactive).
- R2: The clock edge that samples `hdPulse` high sets the pixel count to 0. The pixel count then rises by one per clock. Each output shows the level for pixel k after the (k+1)-th clock edge following that sampling edge.
- R3: A clamp or pre-blank sequence s occupies bits [25s+24:25s] of its configuration vector, laid out as {start, toggle2[11:0], toggle1[11:0]}. At pixel p, the output equals start ^ (p >= toggle1) ^ (p >= toggle2). An active-low pulse therefore uses start = 1.
- R4: Two equal toggle positions cancel, so the output stays at the start level for the whole line. A toggle at position 0 inverts the output from pixel 0 onward.
- R5: The edge that samples `vdPulse` high sets the line count to 0. An `hdPulse` without `vdPulse` advances the line count. Change position k (k = 1..3, bits [12k-1:12k-12]) opens region k at the first pixel of the line whose number equals it. Change positions are programmed in ascending order.
- R6: The region pointer for region r occupies bits [2r+1:2r] of its pointer vector and selects that region's sequence. The optical-black and dummy clamps both use the clamp change positions, and each has its own pointers and sequences.
- R7: The pre-blank selects its region from its own change positions (`pbChg`) and uses its own pointers and sequences.
- R8: When `singleClamp` is high, `clpDmN` equals `clpObN` one cycle later. When it is low, `clpDmN` follows its own pointer and sequence selection.
- R9: A blank sequence s occupies bits [24s+23:24s] of `hbSeq` as {end[11:0], begin[11:0]}. `hBlkN` is high before pixel `begin` and low from `begin` up to, but not including, pixel `end`. Seven boundaries in `hbChg` select among eight regions, each with a pointer in `hbPtr`.
- R10: The pixel count holds at 4095 on lines that run longer than that, so no toggle fires a second time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdPulse | input | 1 | Line sync, restarts the pixel count |
| vdPulse | input | 1 | Field sync, restarts the line count |
| singleClamp | input | 1 | Dummy clamp copies the optical-black clamp |
| obSeq | input | 100 | Four optical-black clamp sequences |
| dmSeq | input | 100 | Four dummy clamp sequences |
| pbSeq | input | 100 | Four pre-blank sequences |
| hbSeq | input | 96 | Four horizontal-blank sequences |
| clpChg | input | 36 | Clamp change positions 1..3 |
| pbChg | input | 36 | Pre-blank change positions 1..3 |
| hbChg | input | 84 | Horizontal-blank region boundaries 1..7 |
| obPtr | input | 8 | Optical-black clamp pointers, regions 0..3 |
| dmPtr | input | 8 | Dummy clamp pointers, regions 0..3 |
| pbPtr | input | 8 | Pre-blank pointers, regions 0..3 |
| hbPtr | input | 16 | Horizontal-blank pointers, regions 0..7 |
| clpObN | output | 1 | Optical-black clamp, active low |
| clpDmN | output | 1 | Dummy clamp, active low |
| pBlkN | output | 1 | Pre-blank, active low |
| hBlkN | output | 1 | Horizontal blank, active low |

## Verification
Each line sync is sampled at one edge. Pixel k of that line is due after the (k+1)-th edge following it, and the line's region takes effect at the same sampling edge. The driver stamps every expected item with that cycle number, and the monitor compares the item at the falling edge of that exact cycle. Configuration changes only after the last due item of the previous line has been compared, so no expected value ever straddles a change of settings.

// File: rtl/hcs_pkg.sv
`timescale 1ns/1ps
package hcs_pkg;
  localparam int PIX_W       = 12;
  localparam int LINE_W      = 12;
  localparam int SEQ_N       = 4;
  localparam int SEQ_W       = $clog2(SEQ_N);
  localparam int CLP_REG_N   = 4;
  localparam int HB_REG_N    = 8;
  localparam int CLP_REG_W   = $clog2(CLP_REG_N);
  localparam int HB_REG_W    = $clog2(HB_REG_N);
  localparam int SEQ_BITS    = 2 * PIX_W + 1;
  localparam int HB_SEQ_BITS = 2 * PIX_W;
  localparam int LANES       = 4;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic [PIX_W-1:0]     pixel;
    logic [CLP_REG_W-1:0] clpRegion;
    logic [CLP_REG_W-1:0] pbRegion;
    logic [HB_REG_W-1:0]  hbRegion;
  } hcs_ctrl_t;
endpackage

// File: rtl/hcs_region_pick.sv
`timescale 1ns/1ps
module hcs_region_pick #(
  parameter int N  = 4,
  parameter int W  = 2,
  parameter int LW = 12
) (
  input  logic [LW-1:0]       line,
  input  logic [(N-1)*LW-1:0] chg,
  output logic [W-1:0]        region
);
  // highest boundary already reached wins; boundaries are ascending
  always_comb begin
    region = '0;
    for (int k = 1; k < N; k++) begin
      if (line >= chg[(k-1)*LW +: LW]) region = W'(k);
    end
  end
endmodule

// File: rtl/hcs_pulse_lane.sv
`timescale 1ns/1ps
module hcs_pulse_lane #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] pix,
  input  logic          startLvl,
  input  logic [PW-1:0] tog1,
  input  logic [PW-1:0] tog2,
  output logic          levelN
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelN <= 1'b1;
    else       levelN <= startLvl ^ (pix >= tog1) ^ (pix >= tog2);
  end
endmodule

// File: rtl/hcs_control.sv
`timescale 1ns/1ps
module hcs_control
  import hcs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hdPulse,
  input  logic                          vdPulse,
  input  logic [(CLP_REG_N-1)*LINE_W-1:0] clpChg,
  input  logic [(CLP_REG_N-1)*LINE_W-1:0] pbChg,
  input  logic [(HB_REG_N-1)*LINE_W-1:0]  hbChg,
  output hcs_ctrl_t                     ctrl,
  output logic [PIX_W-1:0]              pixCnt,
  output logic [LINE_W-1:0]             lineCnt
);
  logic [CLP_REG_W-1:0] clpReg, pbReg;
  logic [HB_REG_W-1:0]  hbReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else begin
      if (hdPulse)            pixCnt <= '0;
      else if (pixCnt != '1)  pixCnt <= pixCnt + 1'b1;
      if (vdPulse)                        lineCnt <= '0;
      else if (hdPulse && lineCnt != '1)  lineCnt <= lineCnt + 1'b1;
    end
  end

  hcs_region_pick #(.N(CLP_REG_N), .W(CLP_REG_W), .LW(LINE_W)) u_clpPick (
    .line(lineCnt), .chg(clpChg), .region(clpReg));
  hcs_region_pick #(.N(CLP_REG_N), .W(CLP_REG_W), .LW(LINE_W)) u_pbPick (
    .line(lineCnt), .chg(pbChg), .region(pbReg));
  hcs_region_pick #(.N(HB_REG_N), .W(HB_REG_W), .LW(LINE_W)) u_hbPick (
    .line(lineCnt), .chg(hbChg), .region(hbReg));

  always_comb begin
    ctrl.pixel     = pixCnt;
    ctrl.clpRegion = clpReg;
    ctrl.pbRegion  = pbReg;
    ctrl.hbRegion  = hbReg;
  end
endmodule

// File: rtl/hcs_datapath.sv
`timescale 1ns/1ps
module hcs_datapath
  import hcs_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  hcs_ctrl_t                    ctrl,
  input  logic                         singleClamp,
  input  logic [SEQ_N*SEQ_BITS-1:0]    obSeq,
  input  logic [SEQ_N*SEQ_BITS-1:0]    dmSeq,
  input  logic [SEQ_N*SEQ_BITS-1:0]    pbSeq,
  input  logic [SEQ_N*HB_SEQ_BITS-1:0] hbSeq,
  input  logic [CLP_REG_N*SEQ_W-1:0]   obPtr,
  input  logic [CLP_REG_N*SEQ_W-1:0]   dmPtr,
  input  logic [CLP_REG_N*SEQ_W-1:0]   pbPtr,
  input  logic [HB_REG_N*SEQ_W-1:0]    hbPtr,
  output logic [LANES-1:0]             laneOut
);
  logic [SEQ_W-1:0]    obIdx, dmIdx, pbIdx, hbIdx;
  logic [SEQ_BITS-1:0] obCfg;
  logic [SEQ_BITS-1:0] laneCfg [LANES];

  always_comb begin
    obIdx = obPtr[ctrl.clpRegion*SEQ_W +: SEQ_W];
    dmIdx = dmPtr[ctrl.clpRegion*SEQ_W +: SEQ_W];
    pbIdx = pbPtr[ctrl.pbRegion*SEQ_W +: SEQ_W];
    hbIdx = hbPtr[ctrl.hbRegion*SEQ_W +: SEQ_W];
    obCfg = obSeq[obIdx*SEQ_BITS +: SEQ_BITS];
    laneCfg[0] = obCfg;
    laneCfg[1] = singleClamp ? obCfg : dmSeq[dmIdx*SEQ_BITS +: SEQ_BITS];
    laneCfg[2] = pbSeq[pbIdx*SEQ_BITS +: SEQ_BITS];
    // blank is idle-high: begin toggles low, end toggles back high
    laneCfg[3] = {1'b1, hbSeq[hbIdx*HB_SEQ_BITS +: HB_SEQ_BITS]};
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    hcs_pulse_lane #(.PW(PIX_W)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .pix      (ctrl.pixel),
      .startLvl (laneCfg[i][SEQ_BITS-1]),
      .tog1     (laneCfg[i][PIX_W-1:0]),
      .tog2     (laneCfg[i][2*PIX_W-1:PIX_W]),
      .levelN   (laneOut[i])
    );
  end
endmodule

// File: rtl/hline_clamp_seq.sv
`timescale 1ns/1ps
module hline_clamp_seq
  import hcs_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          hdPulse,
  input  logic          vdPulse,
  input  logic          singleClamp,
  input  logic [99:0]   obSeq,
  input  logic [99:0]   dmSeq,
  input  logic [99:0]   pbSeq,
  input  logic [95:0]   hbSeq,
  input  logic [35:0]   clpChg,
  input  logic [35:0]   pbChg,
  input  logic [83:0]   hbChg,
  input  logic [7:0]    obPtr,
  input  logic [7:0]    dmPtr,
  input  logic [7:0]    pbPtr,
  input  logic [15:0]   hbPtr,
  output logic          clpObN,
  output logic          clpDmN,
  output logic          pBlkN,
  output logic          hBlkN
);
  hcs_ctrl_t         ctrl;
  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [LANES-1:0]  laneOut;

  hcs_control u_ctrl (
    .clk(clk), .rstN(rstN), .hdPulse(hdPulse), .vdPulse(vdPulse),
    .clpChg(clpChg), .pbChg(pbChg), .hbChg(hbChg),
    .ctrl(ctrl), .pixCnt(pixCnt), .lineCnt(lineCnt));

  hcs_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .singleClamp(singleClamp),
    .obSeq(obSeq), .dmSeq(dmSeq), .pbSeq(pbSeq), .hbSeq(hbSeq),
    .obPtr(obPtr), .dmPtr(dmPtr), .pbPtr(pbPtr), .hbPtr(hbPtr),
    .laneOut(laneOut));

  assign clpObN = laneOut[0];
  assign clpDmN = laneOut[1];
  assign pBlkN  = laneOut[2];
  assign hBlkN  = laneOut[3];
endmodule

// File: rtl/hline_clamp_seq_chk.sv
`timescale 1ns/1ps
module hline_clamp_seq_chk
  import hcs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hdPulse,
  input logic              vdPulse,
  input logic              singleClamp,
  input logic [PIX_W-1:0]  pixCnt,
  input logic [LINE_W-1:0] lineCnt,
  input logic              clpObN,
  input logic              clpDmN
);
  AST_PIX_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    hdPulse |=> pixCnt == '0); // R2
  AST_PIX_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (!hdPulse && pixCnt != '1) |=> pixCnt == $past(pixCnt) + 1'b1); // R2
  AST_PIX_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (!hdPulse && pixCnt == '1) |=> pixCnt == '1); // R10
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    vdPulse |=> lineCnt == '0); // R5
  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (hdPulse && !vdPulse && lineCnt != '1) |=> lineCnt == $past(lineCnt) + 1'b1); // R5
  AST_DM_FOLLOWS_OB: assert property (@(posedge clk) disable iff (!rstN)
    singleClamp |=> clpDmN == clpObN); // R8
endmodule

bind hline_clamp_seq hline_clamp_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .hdPulse(hdPulse), .vdPulse(vdPulse),
  .singleClamp(singleClamp), .pixCnt(pixCnt), .lineCnt(lineCnt),
  .clpObN(clpObN), .clpDmN(clpDmN));

// File: tb/hline_clamp_seq_tb.sv
`timescale 1ns/1ps
module hline_clamp_seq_tb;
  logic clk = 1'b0, rstN = 1'b0, hdPulse = 1'b0, vdPulse = 1'b0, singleClamp = 1'b0;
  logic [99:0] obSeq, dmSeq, pbSeq;
  logic [95:0] hbSeq;
  logic [35:0] clpChgV, pbChgV;
  logic [83:0] hbChgV;
  logic [7:0]  obPtrV, dmPtrV, pbPtrV;
  logic [15:0] hbPtrV;
  logic clpObN, clpDmN, pBlkN, hBlkN;

  // bench-side configuration
  logic        obS[4], dmS[4], pbS[4];
  logic [11:0] obA[4], obB[4], dmA[4], dmB[4], pbA[4], pbB[4], hbA[4], hbB[4];
  logic [11:0] clpChg[7], pbChg[7], hbChg[7];
  logic [1:0]  obP[4], dmP[4], pbP[4], hbP[8];

  always #10 clk = ~clk;

  always_comb begin
    for (int s = 0; s < 4; s++) begin
      obSeq[s*25 +: 25] = {obS[s], obB[s], obA[s]};
      dmSeq[s*25 +: 25] = {dmS[s], dmB[s], dmA[s]};
      pbSeq[s*25 +: 25] = {pbS[s], pbB[s], pbA[s]};
      hbSeq[s*24 +: 24] = {hbB[s], hbA[s]};
      obPtrV[s*2 +: 2] = obP[s];
      dmPtrV[s*2 +: 2] = dmP[s];
      pbPtrV[s*2 +: 2] = pbP[s];
    end
    for (int k = 0; k < 3; k++) begin
      clpChgV[k*12 +: 12] = clpChg[k];
      pbChgV[k*12 +: 12]  = pbChg[k];
    end
    for (int k = 0; k < 7; k++) hbChgV[k*12 +: 12] = hbChg[k];
    for (int r = 0; r < 8; r++) hbPtrV[r*2 +: 2] = hbP[r];
  end

  hline_clamp_seq u_dut (
    .clk(clk), .rstN(rstN), .hdPulse(hdPulse), .vdPulse(vdPulse),
    .singleClamp(singleClamp), .obSeq(obSeq), .dmSeq(dmSeq), .pbSeq(pbSeq),
    .hbSeq(hbSeq), .clpChg(clpChgV), .pbChg(pbChgV), .hbChg(hbChgV),
    .obPtr(obPtrV), .dmPtr(dmPtrV), .pbPtr(pbPtrV), .hbPtr(hbPtrV),
    .clpObN(clpObN), .clpDmN(clpDmN), .pBlkN(pBlkN), .hBlkN(hBlkN));

  typedef struct { int due; int pix; logic [3:0] expv; string tag; } item_t;
  item_t q[$];
  item_t it;
  int cyc = 0, nChk = 0, nBad = 0, curLine = 0;
  string curTag = "";
  logic [3:0] got;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int regionOf(int line, int n, logic [11:0] chg[7]);
    int r = 0;
    for (int k = 1; k < n; k++) if (line >= int'(chg[k-1])) r = k;
    return r;
  endfunction

  function automatic logic lvl(int p, logic s, logic [11:0] a, logic [11:0] b);
    return s ^ (p >= int'(a)) ^ (p >= int'(b));
  endfunction

  // driver: one line, pushes expected levels for every pixel
  task automatic doLine(int len, bit vd);
    int base, p, cr, pr, hr;
    logic o, d;
    hdPulse = 1'b1; vdPulse = vd;
    if (vd) curLine = 0; else if (curLine < 4095) curLine++;
    base = cyc;
    cr = regionOf(curLine, 4, clpChg);
    pr = regionOf(curLine, 4, pbChg);
    hr = regionOf(curLine, 8, hbChg);
    for (int k = 0; k < len; k++) begin
      item_t ni;
      p = (k > 4095) ? 4095 : k;   // R10 counter holds at top
      o = lvl(p, obS[obP[cr]], obA[obP[cr]], obB[obP[cr]]);
      d = singleClamp ? o : lvl(p, dmS[dmP[cr]], dmA[dmP[cr]], dmB[dmP[cr]]);
      ni.due = base + k + 2;
      ni.pix = k;
      ni.expv = {lvl(p, 1'b1, hbA[hbP[hr]], hbB[hbP[hr]]),
                 lvl(p, pbS[pbP[pr]], pbA[pbP[pr]], pbB[pbP[pr]]), d, o};
      ni.tag = curTag;
      q.push_back(ni);
    end
    @(negedge clk); hdPulse = 1'b0; vdPulse = 1'b0;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic idle();
    repeat (4) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      got = {hBlkN, pBlkN, clpDmN, clpObN};
      nChk++;
      if (it.due != cyc || got !== it.expv) begin
        nBad++;
        $display("FAIL %s line=%0d pix=%0d actual={hb,pb,dm,ob}=%b expected=%b",
                 it.tag, curLine, it.pix, got, it.expv);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      obS[s] = 1'b1; obA[s] = 12'(4 + 4*s);  obB[s] = 12'(12 + 5*s);
      dmS[s] = 1'b1; dmA[s] = 12'(1 + 6*s);  dmB[s] = 12'(9 + 7*s);
      pbS[s] = 1'b1; pbA[s] = 12'(20 + 2*s); pbB[s] = 12'(26 + 3*s);
      hbA[s] = 12'(2 + 3*s);  hbB[s] = 12'(30 + 2*s);
      obP[s] = 2'(s); dmP[s] = 2'(3 - s); pbP[s] = 2'(s ^ 1);
    end
    for (int r = 0; r < 8; r++) hbP[r] = 2'((r < 4) ? r : 7 - r);
    for (int k = 0; k < 7; k++) begin
      clpChg[k] = 12'(2 + 2*k); pbChg[k] = 12'(1 + 2*k); hbChg[k] = 12'(k + 1);
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    nChk++;
    if ({hBlkN, pBlkN, clpDmN, clpObN} !== 4'b1111) begin
      nBad++;
      $display("FAIL R1 reset actual=%b expected=1111", {hBlkN, pBlkN, clpDmN, clpObN});
    end
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6 R7 R9: regions across a field, then a field restart
    curTag = "R2/R3/R5/R6/R7/R9 regions";
    doLine(48, 1'b1);
    for (int l = 1; l < 10; l++) doLine(48, 1'b0);
    doLine(48, 1'b1);
    for (int l = 1; l < 4; l++) doLine(48, 1'b0);
    idle();

    // R8 single-clamp on
    singleClamp = 1'b1; curTag = "R8 single clamp";
    idle();
    doLine(40, 1'b1);
    for (int l = 1; l < 8; l++) doLine(40, 1'b0);
    idle();
    singleClamp = 1'b0;

    // R4 equal toggles and toggle at pixel 0; start level low
    curTag = "R4 edge toggles";
    obA[0] = 12'd15; obB[0] = 12'd15;
    pbA[1] = 12'd0;  pbB[1] = 12'd5;
    dmS[3] = 1'b0;   dmA[3] = 12'd8; dmB[3] = 12'd12;
    hbA[0] = 12'd0;  hbB[0] = 12'd0;
    idle();
    doLine(24, 1'b1);
    doLine(24, 1'b0);
    idle();

    // R10 long line, no wrap of the pixel count
    curTag = "R10 saturation";
    obA[0] = 12'd100; obB[0] = 12'd4095;
    idle();
    doLine(4200, 1'b1);
    doLine(16, 1'b0);
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule